// File: doc/BRIEF.md
# SD Card Clock Divider

This block produces the card-side clock of an SD host from its base clock. A single control word holds three clock-enable bits, a linear divisor code, a power-of-two prescaler code and a data-timeout code. The card clock runs only while all three enables are set. Its period in base-clock cycles is the product of the divisor factor and the prescaler factor. A clock-stable flag tells the host when the output has settled after a change. A timeout limit, counted in card-clock cycles, is decoded from the timeout code.

The intended software sequence for a rate change has two writes. The first clears the enables and sets both divider codes to divide-by-1. The second writes the new divider with the enables set. A divider change written while the clock runs is also handled: the output restarts from the start of its low phase. The control word is loaded by a one-cycle write strobe. Nothing is read back through this block.

Top module: `sdclk_divider`

## Requirements
- R1: After reset, `card_clk` and `clk_stable` are 0, and `timeout_limit` is 2^13 because the control word resets to all zeros.
- R2: The divisor code sits in control bits 7:4. Code d gives a divisor factor of d+1, so 0x0 gives 1, 0x3 gives 4, 0x7 gives 8 and 0xF gives 16.
- R3: The prescaler code sits in control bits 15:8. Code 0x00 gives factor 1. A code whose highest set bit is k gives factor 2^(k+1), so 0x01 gives 2 and 0x10 gives 32. Codes that are not one-hot use their highest set bit, so 0x03 gives 4 and 0x90 gives 256.
- R4: The card clock period in base cycles is N = divisor factor × prescaler factor. Divisor 3 with prescaler 0x01 gives 8, and divisor 0xF with prescaler 0x10 gives 512. A product of 1 runs as a period of 2.
- R5: The enables are control bits 0, 1 and 2. If any of them is 0, `card_clk` holds low and the phase returns to its start.
- R6: From phase start, the output is low for ceil(N/2) base cycles and then high for floor(N/2) base cycles, so even N gives a 50% duty cycle. The first edge after the enabling write shows phase 1.
- R7: A write that changes either divider code puts the output back to phase start, low, at the edge that loads the write.
- R8: A write that leaves both divider codes unchanged and keeps all enables set does not disturb `card_clk` or `clk_stable`.
- R9: `clk_stable` is 0 while the clock is disabled and after a divider change. It rises once two full output periods have completed at the new setting, which is 2N base cycles after the enabling or changing write.
- R10: The timeout code sits in control bits 19:16. `timeout_limit` = 2^(13+code) card-clock cycles, so code 0xE gives 2^27. Code 0xF is treated as 0xE.
- R11: The two-write sequence (disable with divide-by-1, then enable with the new divider) keeps the clock low between the writes and then runs at the new rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctrl_we | input | 1 | Strobe that loads the control word on this edge |
| ctrl_wdata | input | 32 | Control word; bits above 19 are ignored |
| card_clk | output | 1 | Divided card clock |
| clk_stable | output | 1 | High once the card clock has settled at its current setting |
| timeout_limit | output | 28 | Data-timeout limit in card-clock cycles |

## Verification
The embedded assertions check these properties on every cycle:
- The output is low whenever an enable is clear.
- The phase counter stays inside the current period.
- A divider write returns the output to phase start.
- The stable flag is high only while the clock runs, and it rises only at the end of a period.

Other properties need the bench's scenarios: the actual period and duty for each encoding, including non-one-hot prescalers and odd divides. The same holds for the exact settle time of 2N cycles, for writes that change only the timeout code leaving the clock undisturbed, and for the two-write reconfiguration sequence. A behavioural model compares all three outputs on every cycle.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // control word field positions (enables at the bottom)
  localparam int EN_IP_BIT   = 0;
  localparam int EN_HOST_BIT = 1;
  localparam int EN_PER_BIT  = 2;
  localparam int DIV_LSB     = 4;

  // number of completed output periods before the clock is declared settled
  localparam int SETTLE_PERIODS = 2;

  // settle counter width for a given period count
  function automatic int settle_width(input int periods);
    return $clog2(periods + 1);
  endfunction
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 4,
  parameter int PRE_W  = 8,
  parameter int TOUT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_code,
  output logic [PRE_W-1:0]  pre_code,
  output logic [TOUT_W-1:0] tout_code,
  output logic              run,
  output logic              run_next,
  output logic              restart
);
  localparam int PRE_LSB  = DIV_LSB + DIV_W;
  localparam int TOUT_LSB = PRE_LSB + PRE_W;
  localparam int CFG_W    = TOUT_LSB + TOUT_W;
  localparam int RATE_W   = DIV_W + PRE_W;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic [CFG_W-1:0] cfg_wr;

  // next-state
  always_comb begin
    cfg_wr = wdata[CFG_W-1:0];
    cfg_d  = we ? cfg_wr : cfg_q;
  end

  // register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    div_code  = cfg_q[DIV_LSB +: DIV_W];
    pre_code  = cfg_q[PRE_LSB +: PRE_W];
    tout_code = cfg_q[TOUT_LSB +: TOUT_W];
    run       = cfg_q[EN_IP_BIT] & cfg_q[EN_HOST_BIT] & cfg_q[EN_PER_BIT];
    run_next  = cfg_d[EN_IP_BIT] & cfg_d[EN_HOST_BIT] & cfg_d[EN_PER_BIT];
    restart   = we && (cfg_wr[DIV_LSB +: RATE_W] != cfg_q[DIV_LSB +: RATE_W]);
  end
endmodule

// File: rtl/sdclk_ratio.sv
module sdclk_ratio #(
  parameter int DIV_W = 4,
  parameter int PRE_W = 8,
  parameter int TOT_W = DIV_W + PRE_W + 1
) (
  input  logic [DIV_W-1:0] div_code,
  input  logic [PRE_W-1:0] pre_code,
  output logic [TOT_W-1:0] eff_period,
  output logic [TOT_W-1:0] low_len
);
  localparam int SH_W = $clog2(PRE_W + 1);

  logic [SH_W-1:0]  pre_shift;
  logic [TOT_W-1:0] total;

  // highest set prescaler bit k selects a shift of k+1; zero selects no shift
  always_comb begin
    pre_shift = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (pre_code[i]) pre_shift = SH_W'(i + 1);
    end
  end

  always_comb begin
    total      = (TOT_W'(div_code) + TOT_W'(1)) << pre_shift;
    eff_period = (total < TOT_W'(2)) ? TOT_W'(2) : total;
    low_len    = eff_period - (eff_period >> 1);
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int TOT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_next,
  input  logic             restart,
  input  logic [TOT_W-1:0] eff_period,
  input  logic [TOT_W-1:0] low_len,
  output logic             card_clk,
  output logic             wrap,
  output logic             phase_clear
);
  logic [TOT_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d;
  logic             cnt_last;

  // next-state
  always_comb begin
    phase_clear = !(run && run_next) || restart;
    cnt_last    = (cnt_q == eff_period - TOT_W'(1));
    wrap        = run && cnt_last;
    if (phase_clear) begin
      cnt_d = '0;
    end else if (cnt_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + TOT_W'(1);
    end
    clk_d = !phase_clear && (cnt_d >= low_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign card_clk = clk_q;

  p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !clk_q);

  p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < eff_period);

  p_restart_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!clk_q && cnt_q == '0));
endmodule

// File: rtl/sdclk_stable.sv
module sdclk_stable
  import sdclk_pkg::*;
#(
  parameter int PERIODS = SETTLE_PERIODS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic phase_clear,
  input  logic wrap,
  output logic stable
);
  localparam int PC_W = settle_width(PERIODS);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_full;

  always_comb begin
    pc_full = (pc_q == PC_W'(PERIODS));
    if (phase_clear) begin
      pc_d = '0;
    end else if (wrap && !pc_full) begin
      pc_d = pc_q + PC_W'(1);
    end else begin
      pc_d = pc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign stable = pc_full;

  p_stable_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stable |-> run);

  p_stable_rises_on_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(wrap));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int DIV_W         = 4,
  parameter int PRE_W         = 8,
  parameter int TOUT_W        = 4,
  parameter int TOUT_BASE     = 13,
  parameter int TOUT_MAX_CODE = 14,
  parameter int TLIM_W        = TOUT_BASE + TOUT_MAX_CODE + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  output logic              card_clk,
  output logic              clk_stable,
  output logic [TLIM_W-1:0] timeout_limit
);
  localparam int TOT_W = DIV_W + PRE_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [DIV_W-1:0]  div_code;
  logic [PRE_W-1:0]  pre_code;
  logic [TOUT_W-1:0] tout_code;
  logic              run, run_next, restart;
  logic [TOT_W-1:0]  eff_period, low_len;
  logic              wrap, phase_clear;

  sdclk_ctrl_reg #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .PRE_W(PRE_W), .TOUT_W(TOUT_W)
  ) u_reg (
    .clk(clk), .rst_n(rst_sync_q), .we(ctrl_we), .wdata(ctrl_wdata),
    .div_code(div_code), .pre_code(pre_code), .tout_code(tout_code),
    .run(run), .run_next(run_next), .restart(restart)
  );

  sdclk_ratio #(
    .DIV_W(DIV_W), .PRE_W(PRE_W), .TOT_W(TOT_W)
  ) u_ratio (
    .div_code(div_code), .pre_code(pre_code),
    .eff_period(eff_period), .low_len(low_len)
  );

  sdclk_gen #(
    .TOT_W(TOT_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_sync_q), .run(run), .run_next(run_next),
    .restart(restart), .eff_period(eff_period), .low_len(low_len),
    .card_clk(card_clk), .wrap(wrap), .phase_clear(phase_clear)
  );

  sdclk_stable #(
    .PERIODS(SETTLE_PERIODS)
  ) u_stable (
    .clk(clk), .rst_n(rst_sync_q), .run(run), .phase_clear(phase_clear),
    .wrap(wrap), .stable(clk_stable)
  );

  // timeout decode, codes above the maximum saturate
  always_comb begin
    int sel;
    sel = (int'(tout_code) > TOUT_MAX_CODE) ? TOUT_MAX_CODE : int'(tout_code);
    timeout_limit = TLIM_W'(1) << (TOUT_BASE + sel);
  end

  p_timeout_single_bit_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones(timeout_limit) == 1);
endmodule

// File: tb/tb_sdclk_divider.sv
module tb_sdclk_divider;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        card_clk;
  logic        clk_stable;
  logic [27:0] timeout_limit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdclk_divider dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .card_clk(card_clk), .clk_stable(clk_stable), .timeout_limit(timeout_limit)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_reg = 0;
  int m_cnt = 0;
  int m_clk = 0;
  int m_pc  = 0;
  bit m_live = 0;

  function automatic int period_of(input int r);
    int d, p, f, n;
    d = (r >> 4) & 15;
    p = (r >> 8) & 255;
    f = 1;
    for (int b = 0; b < 8; b++) if ((p >> b) & 1) f = 2 << b;
    n = (d + 1) * f;
    return (n < 2) ? 2 : n;
  endfunction

  function automatic longint tlim_of(input int r);
    int c;
    c = (r >> 16) & 15;
    if (c > 14) c = 14;
    return longint'(1) << (13 + c);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_cnt = 0; m_clk = 0; m_pc = 0;
    end else begin
      int nreg, n, lowp;
      bit run_now, run_nx, restart, wrap, clr;
      nreg    = ctrl_we ? int'(ctrl_wdata[19:0]) : m_reg;
      run_now = (m_reg & 7) == 7;
      run_nx  = (nreg & 7) == 7;
      restart = ctrl_we && (((nreg >> 4) & 12'hFFF) != ((m_reg >> 4) & 12'hFFF));
      n       = period_of(m_reg);
      lowp    = n - n / 2;
      wrap    = run_now && (m_cnt == n - 1);
      clr     = !(run_now && run_nx) || restart;
      if (clr) begin
        m_cnt = 0; m_clk = 0; m_pc = 0;
      end else begin
        m_cnt = (m_cnt == n - 1) ? 0 : m_cnt + 1;
        m_clk = (m_cnt >= lowp) ? 1 : 0;
        if (wrap && m_pc < 2) m_pc++;
      end
      m_reg = nreg;
    end
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      chk("R6 model card_clk", card_clk, m_clk);
      chk("R9 model clk_stable", clk_stable, (m_pc == 2) ? 1 : 0);
      chk("R10 model timeout_limit", timeout_limit, tlim_of(m_reg));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic settle_time(output int k);
    k = 0;
    while (!clk_stable && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    int guard;
    prev = card_clk;
    guard = 0;
    per = 0;
    hi = 0;
    while (guard < 20000) begin
      @(negedge clk);
      guard++;
      if (!prev && card_clk) break;
      prev = card_clk;
    end
    hi = 1;
    prev = 1'b1;
    while (per < 20000) begin
      @(negedge clk);
      per++;
      if (!prev && card_clk) break;
      if (card_clk) hi++;
      prev = card_clk;
    end
  endtask

  task automatic hold_low(input string req, input int cycles);
    int hits;
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (card_clk || clk_stable) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic rate_case(input string req, input logic [31:0] v,
                           input int exp_per, input int exp_hi);
    int k, per, hi;
    wr(v);
    settle_time(k);
    chk({req, " settle"}, k, 2 * exp_per);
    measure(per, hi);
    chk({req, " period"}, per, exp_per);
    chk({req, " high"}, hi, exp_hi);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    int k, per, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_live = 1;

    // R1 reset state
    chk("R1 card_clk", card_clk, 0);
    chk("R1 clk_stable", clk_stable, 0);
    chk("R1 timeout_limit", timeout_limit, longint'(1) << 13);

    // R4 divide by 8 (divisor 3, prescaler 0x01), R10 code 0xE
    rate_case("R4 div8", 32'h000E_0137, 8, 4);
    chk("R10 code E", timeout_limit, longint'(1) << 27);

    // R8 timeout-only writes leave clock alone
    wr(32'h0000_0137);
    chk("R8 stable kept", clk_stable, 1);
    chk("R10 code 0", timeout_limit, longint'(1) << 13);
    wr(32'h000F_0137);
    chk("R8 stable kept again", clk_stable, 1);
    chk("R10 code F saturates", timeout_limit, longint'(1) << 27);
    measure(per, hi);
    chk("R8 period unchanged", per, 8);

    // R7 divider change while running
    wr(32'h000E_0237);
    chk("R7 restart low", card_clk, 0);
    chk("R7 stable dropped", clk_stable, 0);
    settle_time(k);
    chk("R9 settle 16", k, 32);
    measure(per, hi);
    chk("R3 prescaler 0x02 period", per, 16);

    // R11 two-write sequence to divide by 512
    wr(32'h000E_0000);
    hold_low("R11 low between writes", 40);
    rate_case("R11 div512", 32'h000E_10F7, 512, 256);

    // R5 each enable missing
    wr(32'h000E_0136);
    hold_low("R5 ip enable off", 30);
    wr(32'h000E_0135);
    hold_low("R5 host enable off", 30);
    wr(32'h000E_0133);
    hold_low("R5 peripheral enable off", 30);

    // R3 non-one-hot prescalers
    rate_case("R3 pre 0x03", 32'h0000_0307, 4, 2);
    rate_case("R3 pre 0x90", 32'h0000_9007, 256, 128);

    // R2 divisor codes, R6 odd duty
    rate_case("R2 R6 div3 odd", 32'h0000_0027, 3, 1);
    rate_case("R2 div 8", 32'h0000_0077, 8, 4);

    // R4 product of 1 runs as 2
    rate_case("R4 div1 as 2", 32'h0000_0007, 2, 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule